// File: doc/BRIEF.md
# Multi-Source Trigger Unit

This block merges four trigger sources into one single-cycle trigger pulse. Two of the sources are raw external pins, pin 0 and pin 1. The other two are on-chip strobes: an ADC trigger and a logic-analyzer trigger. Both strobes are already in the block's clock domain. A 32-bit configuration word, held stable by surrounding logic, controls the unit. For each external pin, the word selects any mix of five conditions: low level, high level, any edge, rising edge and falling edge. The word also carries one enable per source.

Each external pin first passes through a two-flop synchronizer. A pin is "hit" when any of its selected conditions is true. The unit forms the OR of all enabled sources, and the output pulses for exactly one cycle each time that combined condition rises. A level condition that stays true therefore fires once and does not fire again until it has dropped. The on-chip strobes are treated as active-high levels.

Top module: `trig_unit`

## Requirements
- R1: After a synchronous reset (rst high), `trig_pulse` is 0. With an all-zero configuration word, no activity on any input produces a pulse.
- R2: Low-level condition: configuration bit i (i = 0 for pin 0, 1 for pin 1) makes pin i hit while its synchronized value is 0.
- R3: High-level condition: configuration bit 2+i makes pin i hit while its synchronized value is 1.
- R4: Any-edge condition: configuration bit 4+i makes pin i hit for one cycle after each change of its synchronized value.
- R5: Rising-edge condition: configuration bit 6+i makes pin i hit for one cycle after each 0-to-1 change, and never on a 1-to-0 change.
- R6: Falling-edge condition: configuration bit 8+i makes pin i hit for one cycle after each 1-to-0 change, and never on a 0-to-1 change.
- R7: Source enables: bit 16 enables pin 0, bit 17 pin 1, bit 18 the ADC trigger and bit 19 the logic-analyzer trigger. A source whose enable is 0 never causes a pulse, whatever its condition bits are.
- R8: Latency: an external pin change applied between clock edges produces the pulse in the third cycle after that change (two synchronizer flops plus the output register). A rise on the ADC or logic-analyzer input produces the pulse in the first cycle.
- R9: The output is high for exactly one cycle per rise of the combined condition. A condition that stays true produces no further pulse until it has fallen and risen again.
- R10: The combined condition is the OR of all selected conditions of all enabled sources. Two conditions set on one pin fire on each of their events. A new source becoming true while another enabled source is already true produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Condition selects and source enables |
| ext_pin | input | 2 | Raw external trigger pins (bit 0 = pin 0) |
| adc_trig | input | 1 | ADC trigger strobe, active high |
| la_trig | input | 1 | Logic-analyzer trigger strobe, active high |
| trig_pulse | output | 1 | One-cycle trigger output |

## Verification
The bench drives each condition alone on one pin. It then steps that pin through a rise, a hold and a fall, which separates the level conditions from the edge conditions and the rising edge from the falling edge. Enable patterns are crossed with activity on the disabled pins, to show that condition bits alone cannot fire the output. A pin and a strobe are compared for timing, which exposes the synchronizer latency. Overlapping sources and dual conditions on one pin show whether the output follows the OR of conditions or fires on each source separately.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CFG_W    = 32;
  localparam int N_PINS   = 2;
  // condition field bases: each field holds one bit per external pin
  localparam int LOW_LSB  = 0;
  localparam int HIGH_LSB = 2;
  localparam int ANY_LSB  = 4;
  localparam int RISE_LSB = 6;
  localparam int FALL_LSB = 8;
  // source enables: pins first, then ADC, then logic analyzer
  localparam int EN_LSB   = 16;
  localparam int EN_ADC   = EN_LSB + N_PINS;
  localparam int EN_LA    = EN_LSB + N_PINS + 1;

  typedef struct packed {
    logic low;
    logic high;
    logic any;
    logic rise;
    logic fall;
  } pin_mode_t;

  function automatic pin_mode_t decode_mode(input logic [CFG_W-1:0] cfg, input int idx);
    pin_mode_t m;
    m.low  = cfg[LOW_LSB  + idx];
    m.high = cfg[HIGH_LSB + idx];
    m.any  = cfg[ANY_LSB  + idx];
    m.rise = cfg[RISE_LSB + idx];
    m.fall = cfg[FALL_LSB + idx];
    return m;
  endfunction

  function automatic logic eval_cond(input pin_mode_t m, input logic cur, input logic prev);
    logic lvl, edg;
    lvl = (m.low & ~cur) | (m.high & cur);
    edg = (m.any & (cur ^ prev)) | (m.rise & cur & ~prev) | (m.fall & ~cur & prev);
    return lvl | edg;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/trig_pin_eval.sv
module trig_pin_eval
  import trig_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_mode_t mode,
  input  logic      cur,
  output logic      hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  assign hit = eval_cond(mode, cur, prev);
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic pulse
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      cond_q <= cond;
      pulse  <= cond & ~cond_q;
    end
  end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [N_PINS-1:0] ext_pin,
  input  logic             adc_trig,
  input  logic             la_trig,
  output logic             trig_pulse
);
  localparam int N_SRC = N_PINS + 2;

  logic [N_PINS-1:0] sync_pin;
  logic [N_PINS-1:0] pin_hit;
  logic [N_SRC-1:0]  src_hit;
  logic [N_SRC-1:0]  src_en;
  logic              comb_cond;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_word[CFG_W-1:EN_LA+1], cfg_word[EN_LSB-1:FALL_LSB+N_PINS]};

  trig_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(ext_pin), .q(sync_pin)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    trig_pin_eval u_eval (
      .clk (clk),
      .rst (rst),
      .mode(decode_mode(cfg_word, p)),
      .cur (sync_pin[p]),
      .hit (pin_hit[p])
    );
  end

  assign src_en  = cfg_word[EN_LA:EN_LSB];
  assign src_hit = {la_trig, adc_trig, pin_hit};
  assign comb_cond = |(src_hit & src_en);

  trig_pulse_gen u_pulse (
    .clk(clk), .rst(rst), .cond(comb_cond), .pulse(trig_pulse)
  );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk
  import trig_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_word,
  input logic [N_PINS-1:0] sync_pin,
  input logic             comb_cond,
  input logic             trig_pulse
);
  // R9: one cycle wide
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);

  // R9: every rise of the combined condition is reported
  a_r9_rise_fires: assert property (@(posedge clk) disable iff (rst)
    $rose(comb_cond) |=> trig_pulse);

  // R9: a pulse needs the condition in the cycle before
  a_r9_pulse_needs_cond: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> $past(comb_cond));

  // R7: with no source enabled, the combined condition stays low
  a_r7_all_disabled: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[EN_LA:EN_LSB] == '0) |-> !comb_cond);

  // R2: low level on pin 0
  a_r2_low_level: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[LOW_LSB] && cfg_word[EN_LSB] && !sync_pin[0]) |-> comb_cond);

  // R5: rising edge on pin 0
  a_r5_rise_edge: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[RISE_LSB] && cfg_word[EN_LSB] && $rose(sync_pin[0])) |-> comb_cond);
endmodule

bind trig_unit trig_unit_chk u_chk (
  .clk(clk), .rst(rst), .cfg_word(cfg_word), .sync_pin(sync_pin),
  .comb_cond(comb_cond), .trig_pulse(trig_pulse)
);

// File: tb/sim_trig_unit.sv
module sim_trig_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic [1:0]  ext_pin = '0;
  logic        adc_trig = 1'b0;
  logic        la_trig = 1'b0;
  logic        trig_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;   // 50 MHz

  trig_unit u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .ext_pin(ext_pin),
    .adc_trig(adc_trig), .la_trig(la_trig), .trig_pulse(trig_pulse)
  );

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // observe n negedges; report pulse count and index of first pulse (0 = none)
  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (trig_pulse) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic expect_fire(input string req, input int exp_cnt, input int exp_first);
    int c, f;
    watch(8, c, f);
    chk(req, "pulse count", c, exp_cnt);
    if (exp_cnt > 0) chk(req, "pulse cycle", f, exp_first);
  endtask

  task automatic t_reset();
    int c, f;
    ext_pin = 2'b11;
    watch(4, c, f);
    chk("R1", "pulse during reset", c, 0);
    rst = 1'b0;
    ext_pin = 2'b00; adc_trig = 1'b1; la_trig = 1'b1;
    watch(6, c, f);
    ext_pin = 2'b11; adc_trig = 1'b0; la_trig = 1'b0;
    watch(6, c, f);
    chk("R1", "pulse with zero config", c, 0);
    ext_pin = 2'b00;
    watch(4, c, f);
  endtask

  task automatic t_low();
    ext_pin[0] = 1'b1;
    expect_fire("R1", 0, 0);
    cfg_word = 32'h0001_0001;          // low level pin 0, enable pin 0
    expect_fire("R2", 0, 0);
    ext_pin[0] = 1'b0;
    expect_fire("R2", 1, 3);
    expect_fire("R9", 0, 0);           // held low: no refire
    cfg_word = '0;
  endtask

  task automatic t_high();
    cfg_word = 32'h0002_0008;          // high level pin 1, enable pin 1
    ext_pin[1] = 1'b1;
    expect_fire("R3", 1, 3);
    expect_fire("R9", 0, 0);
    ext_pin[1] = 1'b0;
    expect_fire("R3", 0, 0);
    ext_pin[1] = 1'b1;
    expect_fire("R9", 1, 3);           // fires again after drop
    cfg_word = '0;
    ext_pin[1] = 1'b0;
    expect_fire("R1", 0, 0);
  endtask

  task automatic t_any();
    cfg_word = 32'h0001_0010;          // any edge pin 0
    ext_pin[0] = 1'b1;
    expect_fire("R4", 1, 3);
    ext_pin[0] = 1'b0;
    expect_fire("R4", 1, 3);
    cfg_word = '0;
  endtask

  task automatic t_rise();
    cfg_word = 32'h0002_0080;          // rising edge pin 1
    ext_pin[1] = 1'b1;
    expect_fire("R5", 1, 3);
    ext_pin[1] = 1'b0;
    expect_fire("R5", 0, 0);
    cfg_word = '0;
  endtask

  task automatic t_fall();
    cfg_word = 32'h0001_0100;          // falling edge pin 0
    ext_pin[0] = 1'b1;
    expect_fire("R6", 0, 0);
    ext_pin[0] = 1'b0;
    expect_fire("R6", 1, 3);
    cfg_word = '0;
  endtask

  task automatic t_enable();
    cfg_word = 32'h0002_00C0;          // rise on both pins, only pin 1 enabled
    ext_pin[0] = 1'b1;
    expect_fire("R7", 0, 0);
    ext_pin[1] = 1'b1;
    expect_fire("R7", 1, 3);
    adc_trig = 1'b1;                   // ADC not enabled
    expect_fire("R7", 0, 0);
    adc_trig = 1'b0;
    ext_pin = 2'b00;
    cfg_word = 32'h0004_0000;          // ADC enabled
    expect_fire("R7", 0, 0);
    adc_trig = 1'b1;
    expect_fire("R8", 1, 1);
    adc_trig = 1'b0;
    cfg_word = 32'h0008_0000;          // LA enabled
    expect_fire("R7", 0, 0);
    la_trig = 1'b1;
    expect_fire("R8", 1, 1);
    la_trig = 1'b0;
    cfg_word = '0;
  endtask

  task automatic t_or();
    cfg_word = 32'h0001_0140;          // rise and fall on pin 0
    ext_pin[0] = 1'b1;
    expect_fire("R10", 1, 3);
    ext_pin[0] = 1'b0;
    expect_fire("R10", 1, 3);
    cfg_word = 32'h0005_0040;          // pin 0 rise plus ADC
    adc_trig = 1'b1;
    expect_fire("R10", 1, 1);
    ext_pin[0] = 1'b1;                 // already true: no new pulse
    expect_fire("R10", 0, 0);
    adc_trig = 1'b0;
    expect_fire("R10", 0, 0);
    cfg_word = '0;
    ext_pin[0] = 1'b0;
    expect_fire("R1", 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_low();
    t_high();
    t_any();
    t_rise();
    t_fall();
    t_enable();
    t_or();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule